// File: doc/BRIEF.md
# Real-Time-Clock Alarm Comparator with Status Flags

This block watches the running calendar counters of a real-time clock and raises an alarm flag when the counters reach a programmed alarm setting. The setting has four fields, each with its own disable bit. A disabled field takes no part in the comparison. The comparison is judged only on a tick pulse, which marks each counter increment. The alarm flag is raised on the first tick of a new match. A match that simply persists from one tick to the next does not raise it again.

The same 8-bit status register holds the alarm flag together with two flags that are set by pulses from the timer logic. Software reads the register directly. A write combines each flag bit with the written bit by a bitwise AND, so one flag can be cleared while the others are kept. The remaining bits are plain control bits, and one of them gates the alarm onto the interrupt line. All pins are plain control and status pins. No streamed data crosses the block edge, so it has no valid/ready handshake and no back-pressure.

Field packing on `cur_fields` and `alm_fields` is field i at bits [i*FW +: FW], with field 0 the minute, 1 the hour, 2 the day and 3 the weekday. Values are plain binary and are compared for equality.

Top module: `rtc_alarm_flags`

## Requirements
- R1: On a cycle where `tick` is 1, the alarm flag (status bit 3) becomes 1 at that clock edge if every enabled field matches and the previous tick did not match. The first tick after reset counts as having no previous match. With `tick` at 0, the flag never sets.
- R2: Once set, the alarm flag stays 1 through any number of further ticks until a status write with bit 3 at 0 clears it.
- R3: After a clear, a match that is still present on later ticks does not set the flag again. A tick without a match followed by a matching tick does set it again.
- R4: A field whose `alm_dis` bit is 1 is left out of the comparison, and its value has no effect. A mismatch on an enabled field prevents the flag from setting.
- R5: When all `alm_dis` bits are 1, the alarm flag never sets.
- R6: On a write, each flag bit becomes the AND of its current value and the written bit. The flags are bit 5 (minute/second flag), bit 3 (alarm) and bit 2 (timer). A written 1 keeps the flag and a written 0 clears it.
- R7: Bits 7, 6, 4, 1 and 0 are control bits that take the written value. Writing the same values again changes neither the flags nor `irq`.
- R8: `irq` is 1 exactly when the alarm flag is 1 and the alarm interrupt enable (status bit 1) is 1.
- R9: When a set event and a write that clears the same flag happen in the same cycle, the flag ends at 1.
- R10: After reset, the status register reads 0x00 (all flags 0, interrupt enable 0) and `irq` is 0.
- R11: A one-cycle pulse on `tf_set` or `msf_set` sets status bit 2 or bit 5 respectively at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse after each counter update |
| cur_fields | input | NF*FW | Current minute, hour, day, weekday |
| alm_fields | input | NF*FW | Alarm setting, same packing |
| alm_dis | input | NF | Per-field disable, 1 leaves the field out |
| tf_set | input | 1 | Timer flag set pulse |
| msf_set | input | 1 | Minute/second flag set pulse |
| wr_en | input | 1 | Status register write strobe |
| wr_data | input | 8 | Status register write value |
| stat_rdata | output | 8 | Status register read value |
| af | output | 1 | Alarm flag |
| tf | output | 1 | Timer flag |
| msf | output | 1 | Minute/second flag |
| irq | output | 1 | Alarm interrupt |

## Verification
Two functions can land in the same cycle: a flag-setting event (a matching tick, or a timer or minute/second pulse) and a software write that clears that same flag. The bench provokes this by first making a tick without a match. It then drives, in one cycle, a matching tick and a `tf_set` pulse together with a write whose bits 3 and 2 are 0. It judges the result by reading both flags as 1 afterwards, while a control bit written in that same cycle is still taken.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int STAT_W   = 8;
  localparam int MSF_BIT  = 5;
  localparam int AF_BIT   = 3;
  localparam int TF_BIT   = 2;
  localparam int AIE_BIT  = 1;
  localparam logic [STAT_W-1:0] FLAG_MASK = (STAT_W'(1) << MSF_BIT)
                                          | (STAT_W'(1) << AF_BIT)
                                          | (STAT_W'(1) << TF_BIT);
  localparam logic [STAT_W-1:0] CTRL_MASK = ~FLAG_MASK;

  typedef struct packed {
    logic msf;
    logic af;
    logic tf;
  } flag_set_t;
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int NF = 4,
  parameter int FW = 7
) (
  input  logic [NF*FW-1:0] cur_fields,
  input  logic [NF*FW-1:0] alm_fields,
  input  logic [NF-1:0]    alm_dis,
  output logic             match_now
);
  logic [NF-1:0] field_ok;

  for (genvar i = 0; i < NF; i++) begin : g_field
    assign field_ok[i] = alm_dis[i] |
                         (cur_fields[i*FW +: FW] == alm_fields[i*FW +: FW]);
  end

  // At least one field must be enabled for a match to exist.
  assign match_now = (&field_ok) & ~(&alm_dis);
endmodule

// File: rtl/rtc_alarm_edge.sv
module rtc_alarm_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic match_now,
  output logic af_set
);
  logic prev_match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_match_q <= 1'b0;
    else if (tick) prev_match_q <= match_now;
  end

  assign af_set = tick & match_now & ~prev_match_q;
endmodule

// File: rtl/rtc_alarm_status.sv
module rtc_alarm_status
  import rtc_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  flag_set_t         set_ev,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat_q
);
  logic [STAT_W-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat_q;
    if (wr_en)
      stat_nxt = (wr_data & CTRL_MASK) | (stat_q & wr_data & FLAG_MASK);
    // Set events applied last: they win over a clearing write.
    if (set_ev.af)  stat_nxt[AF_BIT]  = 1'b1;
    if (set_ev.tf)  stat_nxt[TF_BIT]  = 1'b1;
    if (set_ev.msf) stat_nxt[MSF_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_nxt;
  end
endmodule

// File: rtl/rtc_alarm_flags.sv
module rtc_alarm_flags
  import rtc_alarm_pkg::*;
#(
  parameter int NF = 4,
  parameter int FW = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NF*FW-1:0]  cur_fields,
  input  logic [NF*FW-1:0]  alm_fields,
  input  logic [NF-1:0]     alm_dis,
  input  logic              tf_set,
  input  logic              msf_set,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_data,
  output logic [STAT_W-1:0] stat_rdata,
  output logic              af,
  output logic              tf,
  output logic              msf,
  output logic              irq
);
  logic      match_now;
  logic      af_set;
  flag_set_t set_ev;

  rtc_alarm_cmp #(.NF(NF), .FW(FW)) cmp_i (
    .cur_fields (cur_fields),
    .alm_fields (alm_fields),
    .alm_dis    (alm_dis),
    .match_now  (match_now)
  );

  rtc_alarm_edge edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .match_now (match_now),
    .af_set    (af_set)
  );

  assign set_ev.af  = af_set;
  assign set_ev.tf  = tf_set;
  assign set_ev.msf = msf_set;

  rtc_alarm_status stat_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_ev  (set_ev),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .stat_q  (stat_rdata)
  );

  assign af  = stat_rdata[AF_BIT];
  assign tf  = stat_rdata[TF_BIT];
  assign msf = stat_rdata[MSF_BIT];
  assign irq = stat_rdata[AF_BIT] & stat_rdata[AIE_BIT];
endmodule

// File: rtl/rtc_alarm_flags_chk.sv
module rtc_alarm_flags_chk #(
  parameter int NF = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [NF-1:0] alm_dis,
  input logic          tf_set,
  input logic          wr_en,
  input logic [7:0]    wr_data,
  input logic          af,
  input logic          tf,
  input logic          irq
);
  // R1: no tick, no new alarm
  p_no_set_without_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!af && !tick) |=> !af);

  // R2: alarm flag held unless a clearing write
  p_af_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (af && !(wr_en && !wr_data[3])) |=> af);

  // R5: all fields disabled never raises the alarm
  p_all_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((&alm_dis) && !af) |=> !af);

  // R6: a clearing write without a tick drops the alarm flag
  p_and_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[3] && !tick) |=> !af);

  // R8: interrupt never without alarm
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> af);

  // R9/R11: a timer pulse always lands, even against a clearing write
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tf_set |=> tf);
endmodule

bind rtc_alarm_flags rtc_alarm_flags_chk #(.NF(NF)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .alm_dis (alm_dis),
  .tf_set  (tf_set),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .af      (af),
  .tf      (tf),
  .irq     (irq)
);

// File: tb/rtc_alarm_flags_tb_top.sv
module rtc_alarm_flags_tb_top;
  localparam int NF = 4;
  localparam int FW = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             tick = 1'b0;
  logic [NF*FW-1:0] cur_fields = '0;
  logic [NF*FW-1:0] alm_fields = '0;
  logic [NF-1:0]    alm_dis = '1;
  logic             tf_set = 1'b0;
  logic             msf_set = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = '0;
  logic [7:0]       stat_rdata;
  logic             af, tf, msf, irq;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  rtc_alarm_flags #(.NF(NF), .FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_fields(cur_fields),
    .alm_fields(alm_fields), .alm_dis(alm_dis), .tf_set(tf_set),
    .msf_set(msf_set), .wr_en(wr_en), .wr_data(wr_data),
    .stat_rdata(stat_rdata), .af(af), .tf(tf), .msf(msf), .irq(irq)
  );

  function automatic logic [NF*FW-1:0] pack(input int mi, input int hr,
                                            input int dy, input int wd);
    return {FW'(wd), FW'(dy), FW'(hr), FW'(mi)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Each step drives at a falling edge and leaves outputs settled at the next.
  task automatic do_tick(input logic [NF*FW-1:0] cur);
    cur_fields = cur; tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R10 status", stat_rdata, 8'h00);
    check("R10 irq", irq, 0);
  endtask

  task automatic t_first_match;
    alm_fields = pack(30, 5, 9, 2);
    alm_dis    = 4'b1100;                // day and weekday left out
    cur_fields = pack(30, 5, 17, 6);
    @(negedge clk);
    check("R1 no tick no set", af, 0);
    do_tick(pack(30, 5, 17, 6));
    check("R1/R4 set on first match", af, 1);
    do_tick(pack(31, 5, 17, 6));
    do_tick(pack(32, 5, 17, 6));
    check("R2 sticky across ticks", af, 1);
  endtask

  task automatic t_timer_flags;
    tf_set = 1'b1; @(negedge clk); tf_set = 1'b0;
    check("R11 tf set", tf, 1);
    msf_set = 1'b1; @(negedge clk); msf_set = 1'b0;
    check("R11 msf set", msf, 1);
    do_write(8'h24);                     // keep MSF and TF, clear AF
    check("R6 and-write", stat_rdata, 8'h24);
  endtask

  task automatic t_rematch;
    do_tick(pack(30, 5, 0, 0));
    check("R3 set on new match", af, 1);
    do_write(8'h24);
    check("R3 cleared", af, 0);
    do_tick(pack(30, 5, 0, 0));
    do_tick(pack(30, 5, 0, 0));
    check("R3 persisting match no reset", af, 0);
    do_tick(pack(31, 5, 0, 0));
    do_tick(pack(30, 5, 0, 0));
    check("R3 re-entry sets", af, 1);
  endtask

  task automatic t_irq_ctrl;
    check("R8 irq masked", irq, 0);
    do_write(8'h2E);                     // AIE = bit 1
    check("R8 irq enabled", irq, 1);
    do_write(8'h2E);
    check("R7 rewrite same", stat_rdata, 8'h2E);
    check("R7 rewrite irq", irq, 1);
    do_write(8'hFF);
    check("R7 control bits", stat_rdata, 8'hFF);
    do_write(8'hF7);
    check("R6 clear AF only", stat_rdata, 8'hF7);
    check("R8 irq follows AF", irq, 0);
  endtask

  task automatic t_collision;
    do_tick(pack(31, 5, 0, 0));
    cur_fields = pack(30, 5, 0, 0); tick = 1'b1; tf_set = 1'b1;
    wr_en = 1'b1; wr_data = 8'h20;       // clears AF and TF, AIE to 0
    @(negedge clk);
    tick = 1'b0; tf_set = 1'b0; wr_en = 1'b0;
    check("R9 af set wins", af, 1);
    check("R9 tf set wins", tf, 1);
    check("R9 control still written", stat_rdata, 8'h2C);
  endtask

  task automatic t_disable;
    do_write(8'h00);
    alm_dis = 4'b1110; alm_fields = pack(10, 5, 9, 2);
    do_tick(pack(11, 5, 9, 2));
    do_tick(pack(12, 5, 9, 2));
    check("R4 enabled mismatch blocks", af, 0);
    alm_dis = 4'b1111;
    do_tick(pack(1, 1, 1, 1));
    do_tick(pack(10, 5, 9, 2));
    do_tick(pack(2, 2, 2, 2));
    check("R5 all disabled", af, 0);
  endtask

  bit done = 0;

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_match();
    t_timer_flags();
    t_rematch();
    t_irq_ctrl();
    t_collision();
    t_disable();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule